// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit carries out the basic bit-manipulation operations of an RV32/RV64 integer core: bit counting (leading zeros, trailing zeros, set bits), inverted logic, signed and unsigned minimum and maximum, byte and halfword extension, rotates, byte reversal and the per-byte OR-combine. It takes an operation code, two XLEN-wide operands, an immediate rotate amount and a flag that says whether the hart runs with 64-bit registers.

The arithmetic itself is combinational. The result and an illegal-operation flag are captured in one output register, so each operation presented before a rising clock edge appears at the outputs right after that edge. Word-form operations work on the low 32 bits of a 64-bit datapath. They are refused when the datapath is built 32 bits wide or when the mode flag selects 32-bit operation. Instruction decode, the register file and pipeline control sit outside the unit.

Top module: `bitmanip_alu`

## Requirements
- R1: Operation codes on `op_sel` are 0 clz, 1 ctz, 2 cpop, 3 clzw, 4 ctzw, 5 cpopw, 6 andn, 7 orn, 8 xnor, 9 min, 10 max, 11 minu, 12 maxu, 13 sext.b, 14 sext.h, 15 zext.h, 16 rol, 17 ror, 18 rori, 19 rolw, 20 rorw, 21 roriw, 22 rev8, 23 orc.b. Codes 24 to 31 set `illegal` to 1 and `result` to zero. Whenever `illegal` is 1, `result` is zero.
- R2: Outputs are registered. Operands present before a rising edge are reflected at that edge. While `rst_n` is low at an edge, `result` and `illegal` become 0.
- R3: clz and ctz count leading and trailing zeros across all XLEN bits of `src_a`. A zero operand gives XLEN.
- R4: clzw and ctzw count only within `src_a[31:0]`. A zero low half gives 32, whatever the upper bits hold.
- R5: cpop returns the number of ones in `src_a`. cpopw returns the number of ones in `src_a[31:0]` only.
- R6: andn gives `src_a & ~src_b`, orn gives `src_a | ~src_b`, and xnor gives `~(src_a ^ src_b)`.
- R7: min and max select an operand by two's-complement comparison. minu and maxu select by unsigned comparison.
- R8: sext.b replicates bit 7 of `src_a` above it. sext.h replicates bit 15 above it. zext.h keeps bits 15:0 and clears the rest.
- R9: rol and ror rotate `src_a` across XLEN bits by the low log2(XLEN) bits of `src_b`. rori rotates right by `shamt_imm`.
- R10: rolw, rorw and roriw rotate `src_a[31:0]` within 32 bits by the low 5 bits of `src_b` (or of `shamt_imm` for roriw). Bit 31 of the rotated word fills the upper 32 bits.
- R11: rev8 reverses the order of all XLEN/8 bytes of `src_a`.
- R12: orc.b makes each result byte 0xFF where the matching byte of `src_a` is nonzero and 0x00 where it is zero.
- R13: With `mode64` at 0, the six word-form codes (3, 4, 5, 19, 20, 21) raise `illegal` with a zero result. Full-width operations are unaffected by `mode64`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 5 | Operation code |
| mode64 | input | 1 | 1 when the hart runs with 64-bit registers |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand or register rotate amount |
| shamt_imm | input | log2(XLEN) | Immediate rotate amount |
| result | output | XLEN | Registered result |
| illegal | output | 1 | Registered flag for a refused operation code |

## Verification
The only state is the output register, so any internal fault shows at the ports on the edge right after the offending operands, with no delayed effect to wait for. A wrong count from the shared counters appears as an off-by-one value, most clearly for zero operands and for words whose upper half is busy while the low half is empty. A rotate fault shows up as wrong bits or a missing sign fill when the amount has bits above the meaningful range. A gating fault shows as a nonzero result, or a missing illegal flag, for a word form run in 32-bit mode. Random operand streams with skewed operands are combined with these directed edges.

// File: rtl/bmu_pkg.sv
// Package: shared operation codes for the bit-manipulation unit.
// Assumes: codes are dense from 0; every code from OPS_NUM upward is illegal.
package bmu_pkg;

    localparam int OP_W    = 5;
    localparam int OPS_NUM = 24;

    typedef enum logic [OP_W-1:0] {
        OP_CLZ   = 5'd0,
        OP_CTZ   = 5'd1,
        OP_CPOP  = 5'd2,
        OP_CLZW  = 5'd3,
        OP_CTZW  = 5'd4,
        OP_CPOPW = 5'd5,
        OP_ANDN  = 5'd6,
        OP_ORN   = 5'd7,
        OP_XNOR  = 5'd8,
        OP_MIN   = 5'd9,
        OP_MAX   = 5'd10,
        OP_MINU  = 5'd11,
        OP_MAXU  = 5'd12,
        OP_SEXTB = 5'd13,
        OP_SEXTH = 5'd14,
        OP_ZEXTH = 5'd15,
        OP_ROL   = 5'd16,
        OP_ROR   = 5'd17,
        OP_RORI  = 5'd18,
        OP_ROLW  = 5'd19,
        OP_RORW  = 5'd20,
        OP_RORIW = 5'd21,
        OP_REV8  = 5'd22,
        OP_ORCB  = 5'd23
    } bmu_op_e;

endpackage

// File: rtl/bmu_count.sv
// Module: bit counter producing leading-zero, trailing-zero and set-bit counts.
// Assumes: W >= 2; an all-zero input yields W for both zero counts.
module bmu_count #(
    parameter  int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] lead,
    output logic [CW-1:0] trail,
    output logic [CW-1:0] ones
);

    logic lead_hit;
    logic trail_hit;

    // Scan from the top bit down, counting zeros until the first one.
    always_comb begin
        lead     = '0;
        lead_hit = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!lead_hit) begin
                if (x[i]) lead_hit = 1'b1;
                else      lead     = lead + CW'(1);
            end
        end
    end

    // Scan from the bottom bit up, counting zeros until the first one.
    always_comb begin
        trail     = '0;
        trail_hit = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (!trail_hit) begin
                if (x[i]) trail_hit = 1'b1;
                else      trail     = trail + CW'(1);
            end
        end
    end

    // Sum every bit of the input.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(x[i]);
        end
    end

endmodule

// File: rtl/bmu_rotate.sv
// Module: W-bit rotator, left or right, by an amount of log2(W) bits.
// Assumes: W is a power of two; amount bits above log2(W) are dropped by the caller.
module bmu_rotate #(
    parameter  int W  = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  x,
    input  logic [AW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  y
);

    logic [2*W-1:0] dbl;
    logic [2*W-1:0] dbl_l;
    logic [2*W-1:0] dbl_r;

    // Shift a doubled copy so wrapped bits fall into the kept half.
    always_comb begin
        dbl   = {x, x};
        dbl_l = dbl << amt;
        dbl_r = dbl >> amt;
        y     = left ? dbl_l[2*W-1:W] : dbl_r[W-1:0];
    end

endmodule

// File: rtl/bmu_logic.sv
// Module: non-counting, non-rotating operations: inverted logic, min/max,
// extensions, byte reversal and per-byte OR-combine.
// Assumes: XLEN is a multiple of 8 and at least 16; other codes give zero.
module bmu_logic
    import bmu_pkg::*;
#(
    parameter  int XLEN  = 64,
    localparam int NBYTE = XLEN / 8
) (
    input  bmu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [XLEN-1:0] rev_bytes;
    logic [XLEN-1:0] orc_bytes;
    logic            lt_s;
    logic            lt_u;

    // Byte reversal and per-byte OR-combine, one byte lane at a time.
    always_comb begin
        for (int i = 0; i < NBYTE; i++) begin
            rev_bytes[8*i +: 8] = a[8*(NBYTE-1-i) +: 8];
            orc_bytes[8*i +: 8] = {8{|a[8*i +: 8]}};
        end
    end

    // Signed and unsigned ordering of the two operands.
    always_comb begin
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
    end

    // Pick the output for the operation in hand.
    always_comb begin
        unique case (op)
            OP_ANDN:  y = a & ~b;
            OP_ORN:   y = a | ~b;
            OP_XNOR:  y = ~(a ^ b);
            OP_MIN:   y = lt_s ? a : b;
            OP_MAX:   y = lt_s ? b : a;
            OP_MINU:  y = lt_u ? a : b;
            OP_MAXU:  y = lt_u ? b : a;
            OP_SEXTB: y = {{(XLEN-8){a[7]}}, a[7:0]};
            OP_SEXTH: y = {{(XLEN-16){a[15]}}, a[15:0]};
            OP_ZEXTH: y = {{(XLEN-16){1'b0}}, a[15:0]};
            OP_REV8:  y = rev_bytes;
            OP_ORCB:  y = orc_bytes;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/bitmanip_alu.sv
// Module: top of the bit-manipulation unit. Decodes the operation, routes
// operands to the counter, rotator and logic units, gates word forms, and
// registers the result with an illegal flag.
// Assumes: XLEN is 32 or 64; word forms exist only when XLEN is 64.
module bitmanip_alu
    import bmu_pkg::*;
#(
    parameter  int XLEN = 64,
    localparam int SHW  = $clog2(XLEN),
    localparam int CW   = $clog2(XLEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op_sel,
    input  logic                 mode64,
    input  logic [XLEN-1:0]      src_a,
    input  logic [XLEN-1:0]      src_b,
    input  logic [SHW-1:0]       shamt_imm,
    output logic [XLEN-1:0]      result,
    output logic                 illegal
);

    bmu_op_e         op;
    logic [CW-1:0]   f_lead, f_trail, f_ones;
    logic [SHW-1:0]  f_amt;
    logic [XLEN-1:0] f_rot;
    logic [XLEN-1:0] misc_y;
    logic [XLEN-1:0] w_lead_x, w_trail_x, w_ones_x, w_rot_x;
    logic            word_ok;
    logic            is_word, is_known, legal;
    logic [XLEN-1:0] next_res;

    assign op = bmu_op_e'(op_sel);

    // Full-width counting of the first operand.
    bmu_count #(.W(XLEN)) u_cnt_full (
        .x     (src_a),
        .lead  (f_lead),
        .trail (f_trail),
        .ones  (f_ones)
    );

    // Full-width rotate amount: immediate for rori, register otherwise.
    assign f_amt = (op == OP_RORI) ? shamt_imm : src_b[SHW-1:0];

    bmu_rotate #(.W(XLEN)) u_rot_full (
        .x    (src_a),
        .amt  (f_amt),
        .left (op == OP_ROL),
        .y    (f_rot)
    );

    bmu_logic #(.XLEN(XLEN)) u_logic (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .y  (misc_y)
    );

    // Word-form datapath, present only on a 64-bit build.
    generate
        if (XLEN == 64) begin : g_word
            logic [5:0]  w_lead, w_trail, w_ones;
            logic [4:0]  w_amt;
            logic [31:0] w_rot;

            bmu_count #(.W(32)) u_cnt_word (
                .x     (src_a[31:0]),
                .lead  (w_lead),
                .trail (w_trail),
                .ones  (w_ones)
            );

            assign w_amt = (op == OP_RORIW) ? shamt_imm[4:0] : src_b[4:0];

            bmu_rotate #(.W(32)) u_rot_word (
                .x    (src_a[31:0]),
                .amt  (w_amt),
                .left (op == OP_ROLW),
                .y    (w_rot)
            );

            assign w_lead_x  = {{(XLEN-6){1'b0}}, w_lead};
            assign w_trail_x = {{(XLEN-6){1'b0}}, w_trail};
            assign w_ones_x  = {{(XLEN-6){1'b0}}, w_ones};
            assign w_rot_x   = {{(XLEN-32){w_rot[31]}}, w_rot};
            assign word_ok   = 1'b1;
        end else begin : g_no_word
            assign w_lead_x  = '0;
            assign w_trail_x = '0;
            assign w_ones_x  = '0;
            assign w_rot_x   = '0;
            assign word_ok   = 1'b0;
        end
    endgenerate

    // Classify the code: known at all, and whether it is a word form.
    always_comb begin
        is_known = 32'(op_sel) < OPS_NUM;
        is_word  = (op == OP_CLZW) || (op == OP_CTZW) || (op == OP_CPOPW) ||
                   (op == OP_ROLW) || (op == OP_RORW) || (op == OP_RORIW);
        legal    = is_known && (!is_word || (word_ok && mode64));
    end

    // Select the unit output for the operation.
    always_comb begin
        case (op)
            OP_CLZ:   next_res = {{(XLEN-CW){1'b0}}, f_lead};
            OP_CTZ:   next_res = {{(XLEN-CW){1'b0}}, f_trail};
            OP_CPOP:  next_res = {{(XLEN-CW){1'b0}}, f_ones};
            OP_CLZW:  next_res = w_lead_x;
            OP_CTZW:  next_res = w_trail_x;
            OP_CPOPW: next_res = w_ones_x;
            OP_ROL, OP_ROR, OP_RORI:    next_res = f_rot;
            OP_ROLW, OP_RORW, OP_RORIW: next_res = w_rot_x;
            default:  next_res = misc_y;
        endcase
    end

    // Output register: clear on reset, zero the result of refused codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else begin
            result  <= legal ? next_res : '0;
            illegal <= !legal;
        end
    end

endmodule

// File: rtl/bitmanip_alu_checker.sv
// Module: property checker for bitmanip_alu, bound to every instance.
// Assumes: outputs lag the operands by one edge.
module bitmanip_alu_checker
    import bmu_pkg::*;
#(
    parameter  int XLEN = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OP_W-1:0]      op_sel,
    input logic                 mode64,
    input logic [XLEN-1:0]      src_a,
    input logic [XLEN-1:0]      src_b,
    input logic [XLEN-1:0]      result,
    input logic                 illegal
);

    logic past_ok;

    // Marks cycles whose previous edge already ran out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic bytes_full_or_empty(input logic [XLEN-1:0] v);
        for (int i = 0; i < XLEN / 8; i++) begin
            if (v[8*i +: 8] != 8'h00 && v[8*i +: 8] != 8'hFF) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R1: a refused code never leaves data on the result.
    p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    // R2: the first edge out of reset still shows the cleared outputs.
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (result == '0 && !illegal));

    // R3: counting leading zeros of a zero operand yields XLEN.
    p_clz_zero_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(op_sel) == OP_CLZ && $past(src_a) == '0) |-> (result == XLEN));

    // R5: the word population count cannot exceed 32.
    p_cpopw_bound_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(op_sel) == OP_CPOPW && !illegal) |-> (result <= 32));

    // R7: unsigned minimum returns one of its operands.
    p_minu_pick_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(op_sel) == OP_MINU) |-> (result == $past(src_a) || result == $past(src_b)));

    // R8: byte sign extension fills everything above bit 7 with bit 7.
    p_sextb_fill_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(op_sel) == OP_SEXTB) |-> (result[XLEN-1:8] == {(XLEN-8){result[7]}}));

    // R12: every byte of an OR-combine result is all ones or all zeros.
    p_orcb_bytes_r12: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(op_sel) == OP_ORCB) |-> bytes_full_or_empty(result));

    // R13: word forms in 32-bit mode are refused.
    p_word_gate_r13: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(!mode64) && ($past(op_sel) == OP_CLZW || $past(op_sel) == OP_CTZW ||
          $past(op_sel) == OP_CPOPW || $past(op_sel) == OP_ROLW ||
          $past(op_sel) == OP_RORW || $past(op_sel) == OP_RORIW)) |-> illegal);

    generate
        if (XLEN == 64) begin : g_word_chk
            // R10: word rotates carry bit 31 into the upper half.
            p_rotw_sext_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                (($past(op_sel) == OP_ROLW || $past(op_sel) == OP_RORW ||
                  $past(op_sel) == OP_RORIW) && !illegal)
                |-> (result[63:32] == {32{result[31]}}));
        end
    endgenerate

endmodule

bind bitmanip_alu bitmanip_alu_checker #(.XLEN(XLEN)) u_bitmanip_alu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .mode64  (mode64),
    .src_a   (src_a),
    .src_b   (src_b),
    .result  (result),
    .illegal (illegal)
);

// File: tb/test_bitmanip_alu.sv
`timescale 1ns/1ps
module test_bitmanip_alu;

    localparam int XLEN = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  op_sel;
    logic        mode64;
    logic [63:0] src_a, src_b;
    logic [5:0]  shamt_imm;
    logic [63:0] result;
    logic        illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bitmanip_alu #(.XLEN(XLEN)) i_bitmanip_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .mode64    (mode64),
        .src_a     (src_a),
        .src_b     (src_b),
        .shamt_imm (shamt_imm),
        .result    (result),
        .illegal   (illegal)
    );

    // ---------------- reference model ----------------
    function automatic int cnt_lead(input logic [63:0] v, input int w);
        int n = 0;
        for (int i = w - 1; i >= 0; i--) begin
            if (v[i]) return n;
            n++;
        end
        return n;
    endfunction

    function automatic int cnt_trail(input logic [63:0] v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) begin
            if (v[i]) return n;
            n++;
        end
        return n;
    endfunction

    function automatic int cnt_ones(input logic [63:0] v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [63:0] rl64(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) v = {v[62:0], v[63]};
        return v;
    endfunction

    function automatic logic [31:0] rl32(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) v = {v[30:0], v[31]};
        return v;
    endfunction

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Returns {illegal, result}.
    function automatic logic [64:0] model(input logic [4:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [5:0] imm,
                                          input logic m64);
        logic [63:0] r = '0;
        int sb = int'(b[5:0]);
        int wb = int'(b[4:0]);
        if (op >= 5'd24) return {1'b1, 64'h0};
        if (!m64 && (op inside {5'd3, 5'd4, 5'd5, 5'd19, 5'd20, 5'd21})) return {1'b1, 64'h0};
        case (op)
            5'd0:  r = 64'(cnt_lead(a, 64));
            5'd1:  r = 64'(cnt_trail(a, 64));
            5'd2:  r = 64'(cnt_ones(a, 64));
            5'd3:  r = 64'(cnt_lead({32'h0, a[31:0]}, 32));
            5'd4:  r = 64'(cnt_trail({32'h0, a[31:0]}, 32));
            5'd5:  r = 64'(cnt_ones({32'h0, a[31:0]}, 32));
            5'd6:  r = a & ~b;
            5'd7:  r = a | ~b;
            5'd8:  r = ~(a ^ b);
            5'd9:  r = ($signed(a) < $signed(b)) ? a : b;
            5'd10: r = ($signed(a) > $signed(b)) ? a : b;
            5'd11: r = (a < b) ? a : b;
            5'd12: r = (a > b) ? a : b;
            5'd13: r = 64'($signed(a[7:0]));
            5'd14: r = 64'($signed(a[15:0]));
            5'd15: r = {48'h0, a[15:0]};
            5'd16: r = rl64(a, sb);
            5'd17: r = rl64(a, (64 - sb) % 64);
            5'd18: r = rl64(a, (64 - int'(imm)) % 64);
            5'd19: r = sx32(rl32(a[31:0], wb));
            5'd20: r = sx32(rl32(a[31:0], (32 - wb) % 32));
            5'd21: r = sx32(rl32(a[31:0], (32 - int'(imm[4:0])) % 32));
            5'd22: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[56 - 8*i +: 8];
            default: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
        endcase
        return {1'b0, r};
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic m64);
        if (op >= 5'd24) return "R1";
        if (!m64 && (op inside {5'd3, 5'd4, 5'd5, 5'd19, 5'd20, 5'd21})) return "R13";
        case (op)
            5'd0, 5'd1:          return "R3";
            5'd3, 5'd4:          return "R4";
            5'd2, 5'd5:          return "R5";
            5'd6, 5'd7, 5'd8:    return "R6";
            5'd9, 5'd10, 5'd11, 5'd12: return "R7";
            5'd13, 5'd14, 5'd15: return "R8";
            5'd16, 5'd17, 5'd18: return "R9";
            5'd19, 5'd20, 5'd21: return "R10";
            5'd22:               return "R11";
            default:             return "R12";
        endcase
    endfunction

    // Drive on the falling edge, sample just after the capturing rising edge.
    task automatic run(input string tag, input logic [4:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] imm, input logic m64);
        logic [64:0] exp;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; shamt_imm = imm; mode64 = m64;
        exp = model(op, a, b, imm, m64);
        @(posedge clk);
        #1;
        n_checks++;
        if ({illegal, result} !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%0d m64=%0b: got ill=%0b res=%h, expected ill=%0b res=%h",
                     tag, op, a, b, imm, m64, illegal, result, exp[64], exp[63:0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R2 watchdog expired: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        logic [4:0]  rop;
        logic        rm;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_sel = 5'd0; mode64 = 1'b1;
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = '0; shamt_imm = '0;
        repeat (3) @(posedge clk);
        #1;
        // R2: reset clears outputs even with a live operation on the inputs.
        n_checks++;
        if (result !== 64'h0 || illegal !== 1'b0) begin
            n_fails++;
            $display("FAIL R2 reset state: got ill=%0b res=%h, expected ill=0 res=0", illegal, result);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners.
        run("R2",  5'd2,  64'h0000_0000_0000_00FF, 64'h0, 6'd0, 1'b1);
        run("R3",  5'd0,  64'h0, 64'h0, 6'd0, 1'b1);
        run("R3",  5'd1,  64'h0, 64'h0, 6'd0, 1'b1);
        run("R3",  5'd0,  64'h8000_0000_0000_0000, 64'h0, 6'd0, 1'b1);
        run("R3",  5'd1,  64'h8000_0000_0000_0000, 64'h0, 6'd0, 1'b1);
        run("R4",  5'd3,  64'hFFFF_FFFF_0000_0000, 64'h0, 6'd0, 1'b1);
        run("R4",  5'd4,  64'hFFFF_FFFF_0000_0000, 64'h0, 6'd0, 1'b1);
        run("R4",  5'd3,  64'h0000_0000_0001_0000, 64'h0, 6'd0, 1'b1);
        run("R5",  5'd5,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 1'b1);
        run("R5",  5'd2,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 1'b1);
        run("R6",  5'd6,  64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 6'd0, 1'b1);
        run("R6",  5'd8,  64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 6'd0, 1'b1);
        run("R7",  5'd9,  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 1'b1);
        run("R7",  5'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 1'b1);
        run("R7",  5'd10, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 6'd0, 1'b1);
        run("R8",  5'd13, 64'h0000_0000_0000_0080, 64'h0, 6'd0, 1'b1);
        run("R8",  5'd14, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, 6'd0, 1'b1);
        run("R8",  5'd15, 64'hFFFF_FFFF_FFFF_8001, 64'h0, 6'd0, 1'b1);
        run("R9",  5'd16, 64'h8000_0000_0000_0001, 64'd65, 6'd0, 1'b1);
        run("R9",  5'd17, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC4, 6'd0, 1'b1);
        run("R9",  5'd18, 64'h0123_4567_89AB_CDEF, 64'h0, 6'd63, 1'b1);
        run("R10", 5'd19, 64'hAAAA_AAAA_4000_0000, 64'd33, 6'd0, 1'b1);
        run("R10", 5'd20, 64'h0000_0000_0000_0001, 64'd1, 6'd0, 1'b1);
        run("R10", 5'd21, 64'hFFFF_FFFF_0000_0002, 64'h0, 6'd33, 1'b1);
        run("R11", 5'd22, 64'h0102_0304_0506_0708, 64'h0, 6'd0, 1'b1);
        run("R12", 5'd23, 64'h0100_8000_0000_FF01, 64'h0, 6'd0, 1'b1);
        run("R13", 5'd20, 64'h0000_0000_0000_0001, 64'd1, 6'd0, 1'b0);
        run("R13", 5'd3,  64'h0, 64'h0, 6'd0, 1'b0);
        run("R13", 5'd0,  64'h0, 64'h0, 6'd0, 1'b0);
        run("R1",  5'd27, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd5, 1'b1);
        run("R1",  5'd31, 64'h1, 64'h2, 6'd1, 1'b1);

        // Random stream with skewed operands.
        for (int k = 0; k < 3000; k++) begin
            rop = 5'($urandom % 32);
            ra  = {$urandom, $urandom};
            rb  = {$urandom, $urandom};
            case ($urandom % 6)
                0: ra = '0;
                1: ra = {32'($urandom), 32'h0};
                2: ra = ra >> ($urandom % 64);
                3: rb = ra;
                default: ;
            endcase
            rm = ($urandom % 5) != 0;
            run(tag_of(rop, rm), rop, ra, rb, 6'($urandom), rm);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule